// File: doc/BRIEF.md
# Memory-Controller Event Counter Bank

This block is a performance monitor that sits beside a DRAM controller and counts controller events for software. Eight programmable counters each pick events from a strobe vector through a per-counter bitmap. They count only inside a window that software opens and closes explicitly, and only while manual mode is selected. Two more counters, one for DRAM writes and one for DRAM reads, run freely outside that window. Each of the two has its own enable bit and its own clear strobe.

Software reaches the bank through a 64-bit register port made of a write strobe and a read strobe that share one address. Read data comes back registered, with a valid flag, one cycle after the read strobe. Every counter saturates at all ones and does not wrap. Software treats the all-ones value as overflow.

Top module: `mc_evt_counter_bank`

## Requirements
- R1: After reset every counter reads zero, and the mode, window-active, end-done, configuration and free-run enable registers all read zero.
- R2: Writing bit 0 at 0x8020 sets or clears manual mode, and that register reads it back on bit 0. Writing bit 0 = 1 at 0x8028 while manual mode is set opens the window: it sets the active flag (bit 1 of a 0x8028 read), clears the end-done flag and zeroes all programmable counters. The same write has no effect while manual mode is clear.
- R3: Writing bit 0 = 1 at 0x8030 closes the window. After it, bit 1 of a 0x8028 read is 0 and bit 0 of a 0x8038 read is 1.
- R4: The configuration register of counter n sits at 0x8040 + 8n. Bit 63 enables the counter and bits [EVT_W-1:0] hold its event bitmap. Only those bits read back; all other bits read 0.
- R5: The value of programmable counter n reads at 0x8080 + 8n. The counter increases by exactly one in every cycle in which it is enabled, the window is active and at least one strobe selected by its bitmap is high. It still increases by only one when several selected strobes are high in the same cycle.
- R6: Outside the window, or while disabled, a programmable counter holds its value.
- R7: Bit 0 at 0x80C0 enables the write counter, which counts `wr_evt_i`. Bit 1 enables the read counter, which counts `rd_evt_i`. Both count regardless of the window. The write count reads at 0x80D0 and the read count at 0x80D8.
- R8: Writing 0x80C8 with bit 0 set zeroes the write counter, and with bit 1 set zeroes the read counter. A clear wins over an event in the same cycle, and 0x80C8 reads as 0.
- R9: Every counter stops at 2^CNT_W - 1 and stays there while events continue.
- R10: Any address outside the map reads 0, and writes to it change nothing. Writes to the value registers are ignored.
- R11: `rvalid_o` is high exactly in the cycle after `rd_en_i`, and `rdata_o` then carries the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, registered |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| evt_i | input | EVT_W | Event strobes from the controller |
| wr_evt_i | input | 1 | DRAM write event strobe |
| rd_evt_i | input | 1 | DRAM read event strobe |

## Verification
The event vector is driven with single selected bits, with two selected bits in the same cycle, with bits a counter does not select, and with events before the window opens and after it closes. Together these separate counting from bitmap matching and from window gating, and they show that one cycle adds one count. The free-running counters receive simultaneous read and write strobes while only one of them is enabled. A clear is issued in the same cycle as an event, which shows that the clear wins. A second instance with 4-bit counters receives the same stimulus. It shows a counter pinning at all ones while the wide instance keeps counting.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int unsigned REG_MODE     = 32'h8020;
  localparam int unsigned REG_START    = 32'h8028;
  localparam int unsigned REG_END      = 32'h8030;
  localparam int unsigned REG_STATUS   = 32'h8038;
  localparam int unsigned REG_CFG_BASE = 32'h8040;
  localparam int unsigned REG_VAL_BASE = 32'h8080;
  localparam int unsigned REG_FREE_EN  = 32'h80C0;
  localparam int unsigned REG_FREE_CLR = 32'h80C8;
  localparam int unsigned REG_FREE_WR  = 32'h80D0;
  localparam int unsigned REG_FREE_RD  = 32'h80D8;
  localparam int unsigned REG_STRIDE   = 8;
  localparam int unsigned CFG_EN_BIT   = 63;
endpackage

// File: rtl/mcb_sat_counter.sv
module mcb_sat_counter #(
  parameter int unsigned CNT_W = 49
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (clr_i)              cnt_o <= '0;
    else if (inc_i && !(&cnt_o)) cnt_o <= cnt_o + 1'b1;
  end

  assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o && !clr_i) |=> &cnt_o);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));
  assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !(&cnt_o)) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/mcb_window_ctrl.sv
module mcb_window_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_wr_i,
  input  logic mode_d_i,
  input  logic start_i,
  input  logic end_i,
  output logic manual_o,
  output logic active_o,
  output logic done_o,
  output logic restart_o
);
  assign restart_o = start_i & manual_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      manual_o <= 1'b0;
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      if (mode_wr_i) manual_o <= mode_d_i;
      if (end_i) begin
        active_o <= 1'b0;
        done_o   <= 1'b1;
      end else if (restart_o) begin
        active_o <= 1'b1;
        done_o   <= 1'b0;
      end
    end
  end

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && manual_o && !end_i) |=> (active_o && !done_o));
  assert_start_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !manual_o && !active_o) |=> !active_o);
  assert_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> (!active_o && done_o));
endmodule

// File: rtl/mc_evt_counter_bank.sv
module mc_evt_counter_bank
  import mcb_pkg::*;
#(
  parameter int unsigned NUM_GEN = 8,
  parameter int unsigned EVT_W   = 16,
  parameter int unsigned CNT_W   = 49,
  parameter int unsigned ADDR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output logic              rvalid_o,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              wr_evt_i,
  input  logic              rd_evt_i
);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(REG_MODE);
  localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(REG_START);
  localparam logic [ADDR_W-1:0] A_END    = ADDR_W'(REG_END);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_FEN    = ADDR_W'(REG_FREE_EN);
  localparam logic [ADDR_W-1:0] A_FCLR   = ADDR_W'(REG_FREE_CLR);
  localparam logic [ADDR_W-1:0] A_FWR    = ADDR_W'(REG_FREE_WR);
  localparam logic [ADDR_W-1:0] A_FRD    = ADDR_W'(REG_FREE_RD);

  logic             manual, active, done, restart, count_en;
  logic [1:0]       free_en_q;
  logic             cfg_en_q  [NUM_GEN];
  logic [EVT_W-1:0] cfg_map_q [NUM_GEN];
  logic [CNT_W-1:0] gen_cnt   [NUM_GEN];
  logic [CNT_W-1:0] fwr_cnt, frd_cnt;
  logic             fclr_hit;
  logic [63:0]      rd_mux;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign fclr_hit     = wr_en_i && (addr_i == A_FCLR);
  assign count_en     = active & manual;

  mcb_window_ctrl u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_wr_i (wr_en_i && (addr_i == A_MODE)),
    .mode_d_i  (wdata_i[0]),
    .start_i   (wr_en_i && (addr_i == A_START) && wdata_i[0]),
    .end_i     (wr_en_i && (addr_i == A_END) && wdata_i[0]),
    .manual_o  (manual),
    .active_o  (active),
    .done_o    (done),
    .restart_o (restart)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              free_en_q <= '0;
    else if (wr_en_i && (addr_i == A_FEN))    free_en_q <= wdata_i[1:0];
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(REG_CFG_BASE + REG_STRIDE * g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_en_q[g]  <= 1'b0;
        cfg_map_q[g] <= '0;
      end else if (wr_en_i && (addr_i == A_CFG)) begin
        cfg_en_q[g]  <= wdata_i[CFG_EN_BIT];
        cfg_map_q[g] <= wdata_i[EVT_W-1:0];
      end
    end

    mcb_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (restart),
      .inc_i  (cfg_en_q[g] && count_en && (|(cfg_map_q[g] & evt_i))),
      .cnt_o  (gen_cnt[g])
    );
  end

  mcb_sat_counter #(.CNT_W(CNT_W)) u_fwr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fclr_hit && wdata_i[0]),
    .inc_i  (free_en_q[0] && wr_evt_i),
    .cnt_o  (fwr_cnt)
  );

  mcb_sat_counter #(.CNT_W(CNT_W)) u_frd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fclr_hit && wdata_i[1]),
    .inc_i  (free_en_q[1] && rd_evt_i),
    .cnt_o  (frd_cnt)
  );

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_MODE:   rd_mux = 64'(manual);
      A_START:  rd_mux = {62'd0, active, 1'b0};
      A_STATUS: rd_mux = 64'(done);
      A_FEN:    rd_mux = 64'(free_en_q);
      A_FWR:    rd_mux = 64'(fwr_cnt);
      A_FRD:    rd_mux = 64'(frd_cnt);
      default:  rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_GEN; i++) begin
      if (addr_i == ADDR_W'(REG_CFG_BASE + REG_STRIDE * i)) begin
        rd_mux = 64'(cfg_map_q[i]);
        rd_mux[CFG_EN_BIT] = cfg_en_q[i];
      end
      if (addr_i == ADDR_W'(REG_VAL_BASE + REG_STRIDE * i))
        rd_mux = 64'(gen_cnt[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  assert_rvalid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  assert_rvalid_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  assert_free_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_en_q[0] && !fclr_hit) |=> $stable(fwr_cnt));
endmodule

// File: tb/tb_mc_evt_counter_bank.sv
module tb_mc_evt_counter_bank;
  localparam int unsigned EVT_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [EVT_W-1:0] evt = '0;
  logic        wr_evt = 1'b0, rd_evt = 1'b0;
  logic [63:0] rdata, rdata_s;
  logic        rvalid, rvalid_s;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [63:0] q_exp[$];
  logic [63:0] q_exp_s[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  mc_evt_counter_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .evt_i(evt),
    .wr_evt_i(wr_evt), .rd_evt_i(rd_evt));

  mc_evt_counter_bank #(.CNT_W(4)) dut_s (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_s), .rvalid_o(rvalid_s), .evt_i(evt),
    .wr_evt_i(wr_evt), .rd_evt_i(rd_evt));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [63:0] e, input logic [63:0] es, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    q_exp.push_back(e); q_exp_s.push_back(es); q_tag.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [EVT_W-1:0] v, input int n);
    @(negedge clk); evt = v;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  // monitor: pops one expectation per returned read
  always @(negedge clk) begin
    if (rst_n && (rvalid || rvalid_s)) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R11 unexpected rvalid", 64'(rvalid), 64'd0);
      end else begin
        logic [63:0] e, es;
        string t;
        e = q_exp.pop_front(); es = q_exp_s.pop_front(); t = q_tag.pop_front();
        check(rvalid && rvalid_s, {t, " R11 valid"}, 64'({rvalid, rvalid_s}), 64'd3);
        check(rdata === e, t, rdata, e);
        check(rdata_s === es, {t, " (4-bit)"}, rdata_s, es);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(16'h8020, 0, 0, "R1 mode");
    rd(16'h8028, 0, 0, "R1 active");
    rd(16'h8038, 0, 0, "R1 done");
    rd(16'h8040, 0, 0, "R1 cfg0");
    rd(16'h8080, 0, 0, "R1 cnt0");
    rd(16'h80D0, 0, 0, "R1 free wr");
    rd(16'h80C0, 0, 0, "R1 free en");
    // R2 start ignored outside manual mode
    wr(16'h8028, 1);
    rd(16'h8028, 0, 0, "R2 start ignored");
    wr(16'h8020, 1);
    rd(16'h8020, 1, 1, "R2 manual set");
    // R4 configuration
    wr(16'h8040, 64'h8000_0000_0000_0003);
    wr(16'h8048, 64'h8000_0000_0000_0004);
    wr(16'h8050, 64'h0000_0000_0000_0001);
    wr(16'h8058, '1);
    rd(16'h8040, 64'h8000_0000_0000_0003, 64'h8000_0000_0000_0003, "R4 cfg0");
    rd(16'h8058, 64'h8000_0000_0000_FFFF, 64'h8000_0000_0000_FFFF, "R4 cfg3 masked");
    // R6 no counting before window
    pulse(16'h0001, 3);
    rd(16'h8080, 0, 0, "R6 pre-window");
    wr(16'h8028, 1);
    rd(16'h8028, 2, 2, "R2 active");
    rd(16'h8038, 0, 0, "R2 done cleared");
    // R5 counting patterns
    pulse(16'h0001, 4);
    pulse(16'h0003, 2);
    pulse(16'h0004, 5);
    pulse(16'h0008, 3);
    wr(16'h8030, 1);
    rd(16'h8028, 0, 0, "R3 inactive");
    rd(16'h8038, 1, 1, "R3 done");
    pulse(16'h0001, 5);
    rd(16'h8080, 6, 6, "R5 cnt0 bitmap/one per cycle");
    rd(16'h8088, 5, 5, "R5 cnt1");
    rd(16'h8090, 0, 0, "R5 cnt2 disabled");
    rd(16'h8098, 14, 14, "R6 cnt3 holds after end");
    // R2 restart clears
    wr(16'h8028, 1);
    rd(16'h8080, 0, 0, "R2 restart clears");
    rd(16'h8038, 0, 0, "R2 restart clears done");
    wr(16'h8030, 1);
    // R7 free-running
    wr(16'h80C0, 1);
    @(negedge clk); wr_evt = 1'b1; rd_evt = 1'b1;
    repeat (3) @(negedge clk);
    wr_evt = 1'b0; rd_evt = 1'b0;
    rd(16'h80D0, 3, 3, "R7 write count");
    rd(16'h80D8, 0, 0, "R7 read disabled");
    rd(16'h80C0, 1, 1, "R7 enable readback");
    wr(16'h80C0, 3);
    @(negedge clk); rd_evt = 1'b1;
    repeat (4) @(negedge clk);
    rd_evt = 1'b0;
    rd(16'h80D8, 4, 4, "R7 read count");
    // R8 clear wins over event
    @(negedge clk); wr_evt = 1'b1;
    wr(16'h80C8, 1);
    wr_evt = 1'b0;
    rd(16'h80D0, 0, 0, "R8 write clear wins");
    rd(16'h80D8, 4, 4, "R8 read untouched");
    rd(16'h80C8, 0, 0, "R8 reads zero");
    wr(16'h80C8, 2);
    rd(16'h80D8, 0, 0, "R8 read clear");
    // R10 unmapped / read-only
    wr(16'h9000, '1);
    rd(16'h9000, 0, 0, "R10 unmapped read");
    rd(16'h8100, 0, 0, "R10 unmapped read 2");
    rd(16'h8020, 1, 1, "R10 mode untouched");
    wr(16'h80D8, 64'h55);
    rd(16'h80D8, 0, 0, "R10 value write ignored");
    // R9 saturation (4-bit instance pins at 15)
    wr(16'h8028, 1);
    pulse(16'h0001, 20);
    rd(16'h8080, 20, 15, "R9 saturate");
    pulse(16'h0001, 5);
    rd(16'h8080, 25, 15, "R9 stays saturated");
    rd(16'h8098, 25, 15, "R9 cnt3");
    rd(16'h8088, 0, 0, "R5 cnt1 unselected");
    // R11 idle
    repeat (2) @(negedge clk);
    check(!rvalid && !rvalid_s, "R11 idle rvalid", 64'(rvalid), 64'd0);
    check(q_exp.size() == 0, "R11 all reads returned", 64'(q_exp.size()), 64'd0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule